// File: doc/BRIEF.md
# Multi-Mode Load Modulation Encoder

This block produces the damping-switch control for a passive RF tag that answers a reader by load modulation. Every clock cycle is one cycle of the field clock. A programmable divider turns that clock into a bit period. Each bit taken from the serial input is then coded onto the damping output with one scheme, chosen by a 5-bit mode code. The schemes are plain level (NRZ), Manchester, biphase, four two-tone FSK pairings and three PSK variants. The PSK variants share a subcarrier of RF/2, RF/4 or RF/8.

A bit is handed over with a level handshake. The encoder takes `data_bit` at any rising edge where `data_valid` is high and it is either idle or in the last cycle of a bit. That last cycle is marked by `bit_done`, so a source that holds `data_valid` high and moves to its next bit after each `bit_done` gets an unbroken stream. If `data_valid` is low at the end of a bit, the encoder goes idle and releases the damping switch. The configuration inputs are assumed to change only while the encoder is idle.

Top module: `lm_encoder`

## Requirements
- R1: With `rate_compat`=0, a bit lasts 2*(`rate_code`+1) field clocks, so the codes 0 to 63 give RF/2 to RF/128. `bit_done` is high in exactly the last of those clocks.
- R2: With `rate_compat`=1, `rate_code[2:0]` picks the bit length from this table: 0→8, 1→16, 2→32, 3→40, 4→50, 5→64, 6→100, 7→128 clocks.
- R3: Mode 00000 (NRZ) holds `damp` equal to the bit for the whole bit.
- R4: Mode 01000 (Manchester) drives the inverse of the bit for the first half (clock index below length/2) and the bit itself for the second half. A 0 therefore falls at mid-bit and a 1 rises.
- R5: Mode 10000 (biphase) starts the first bit after idle at level 1. Each later bit starts at the opposite of the level that ended the bit before it. A bit of 1 toggles again at clock index length/2.
- R6: Modes 00100, 00101, 00110 and 00111 emit a square subcarrier whose period depends on the bit. For 00100 a 0 uses 5 clocks and a 1 uses 8. For 00101 a 0 uses 10 and a 1 uses 8. For 00110 a 0 uses 8 and a 1 uses 5. For 00111 a 0 uses 8 and a 1 uses 10. The subcarrier is high for the first ceil(period/2) clocks of each period and restarts at clock 0 of every bit.
- R7: In the PSK modes, `psk_sel` 00, 01 and 10 give a subcarrier period Q of 2, 4 and 8 clocks. The carrier is high when (clock index mod Q) < Q/2, and it is XORed with a phase flag. The bit length must be a multiple of Q.
- R8: The phase flag is set at each bit start, taking phase 0 and a previous bit of 0 after idle. Mode 00001 flips the phase when the bit differs from the previous bit. Mode 00010 flips it for every 1. Mode 00011 flips it only when the previous bit is 0 and the new bit is 1.
- R9: `invert`=1 inverts `damp` in every valid mode while a bit is in progress.
- R10: After reset, while idle, in a reserved mode code, and with `psk_sel`=11 in a PSK mode, `damp` is 0 whatever `invert` is. The bit timing still runs in reserved modes.
- R11: A bit is taken at an edge where `data_valid` is high and the encoder is idle or `bit_done` is high. The bit starts at clock index 0 on the next cycle. If `data_valid` is low during `bit_done`, the encoder is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Field clock, one cycle per RF period |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_compat | input | 1 | 1 selects the fixed bit-length table, 0 the linear divider |
| rate_code | input | RATE_W | Bit-length code |
| mod_sel | input | 5 | Coding scheme code |
| psk_sel | input | 2 | PSK subcarrier period code |
| invert | input | 1 | Inverts the damping output |
| data_bit | input | 1 | Next bit to send |
| data_valid | input | 1 | `data_bit` holds a bit to send |
| damp | output | 1 | Damping switch control, 1 = load on |
| bit_done | output | 1 | High in the last clock of the current bit |

## Verification
The end of one bit and the start of the next fall on the same edge. At that edge the divider restarts, the PSK phase and the biphase level are updated from the old and new bits, and the FSK subcarrier is cut short and restarted. The bench provokes this collision by streaming bits back to back with `data_valid` held high. It covers the shortest bit (two clocks), where the Manchester mid-bit change and the boundary sit in adjacent cycles. Each cycle, the bench compares the damping level with a model worked out from the coding rules, and it checks that `bit_done` stands only in the final clock.

// File: rtl/lm_enc_pkg.sv
// Package: shared scheme decode, mode codes and rate tables for the
// load modulation encoder. Assumes 5-bit mode codes and 3-bit table codes.
package lm_enc_pkg;

    localparam int SUB_W = 4;

    typedef enum logic [2:0] {
        SCH_OFF,
        SCH_NRZ,
        SCH_PSK,
        SCH_FSK,
        SCH_MAN,
        SCH_BIP
    } scheme_e;

    localparam logic [4:0] MODE_NRZ    = 5'b00000;
    localparam logic [4:0] MODE_PSK_CH = 5'b00001;
    localparam logic [4:0] MODE_PSK_HI = 5'b00010;
    localparam logic [4:0] MODE_PSK_UP = 5'b00011;
    localparam logic [4:0] MODE_FSK_A  = 5'b00100;
    localparam logic [4:0] MODE_FSK_B  = 5'b00101;
    localparam logic [4:0] MODE_FSK_AR = 5'b00110;
    localparam logic [4:0] MODE_FSK_BR = 5'b00111;
    localparam logic [4:0] MODE_MAN    = 5'b01000;
    localparam logic [4:0] MODE_BIP    = 5'b10000;

    // Map a mode code onto its coding family; unlisted codes are reserved.
    function automatic scheme_e scheme_of(input logic [4:0] m);
        case (m)
            MODE_NRZ:                             return SCH_NRZ;
            MODE_PSK_CH, MODE_PSK_HI, MODE_PSK_UP: return SCH_PSK;
            MODE_FSK_A, MODE_FSK_B,
            MODE_FSK_AR, MODE_FSK_BR:             return SCH_FSK;
            MODE_MAN:                             return SCH_MAN;
            MODE_BIP:                             return SCH_BIP;
            default:                              return SCH_OFF;
        endcase
    endfunction

    // Fixed bit-length table used in compatibility rate mode.
    function automatic logic [7:0] table_period(input logic [2:0] c);
        case (c)
            3'd0:    return 8'd8;
            3'd1:    return 8'd16;
            3'd2:    return 8'd32;
            3'd3:    return 8'd40;
            3'd4:    return 8'd50;
            3'd5:    return 8'd64;
            3'd6:    return 8'd100;
            default: return 8'd128;
        endcase
    endfunction

    // FSK subcarrier period for a given mode and bit value.
    function automatic logic [SUB_W-1:0] fsk_period(input logic [4:0] m, input logic b);
        case (m)
            MODE_FSK_A:  return b ? SUB_W'(8)  : SUB_W'(5);
            MODE_FSK_B:  return b ? SUB_W'(8)  : SUB_W'(10);
            MODE_FSK_AR: return b ? SUB_W'(5)  : SUB_W'(8);
            MODE_FSK_BR: return b ? SUB_W'(10) : SUB_W'(8);
            default:     return SUB_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/lm_bit_timer.sv
// Bit timer: derives the bit length from the rate inputs, counts field
// clocks within a bit, runs the input handshake and flags the final clock.
// Assumes the rate inputs are stable while a bit is in progress.
module lm_bit_timer
    import lm_enc_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int PER_W  = RATE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_compat,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              data_bit,
    input  logic              data_valid,
    output logic              active,
    output logic              cur_bit,
    output logic [PER_W-1:0]  cnt,
    output logic [PER_W-1:0]  period,
    output logic              load,
    output logic              bit_done
);

    logic [PER_W-1:0] last_idx;

    // Bit length in field clocks from the selected rate encoding.
    always_comb begin
        if (rate_compat)
            period = PER_W'(table_period(rate_code[2:0]));
        else
            period = PER_W'({rate_code, 1'b0}) + PER_W'(2);
        last_idx = period - PER_W'(1);
    end

    // End-of-bit flag and acceptance of the next bit.
    always_comb begin
        bit_done = active && (cnt == last_idx);
        load     = data_valid && (!active || bit_done);
    end

    // Bit counter, busy flag and the bit being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            cur_bit <= 1'b0;
        end else if (load) begin
            active  <= 1'b1;
            cnt     <= '0;
            cur_bit <= data_bit;
        end else if (bit_done) begin
            active  <= 1'b0;
            cnt     <= '0;
        end else if (active) begin
            cnt     <= cnt + PER_W'(1);
        end
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt < period));

    assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_done && !data_valid) |=> !active);

    assert_load_restarts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active && cnt == '0));

endmodule

// File: rtl/lm_carrier.sv
// Carrier state: the FSK subcarrier counter, the PSK phase flag and the
// biphase start level, all updated when a new bit is taken.
// Assumes the mode input is stable while a bit is in progress.
module lm_carrier
    import lm_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             load,
    input  logic             data_bit,
    input  logic             cur_bit,
    input  logic [4:0]       mod_sel,
    output logic [SUB_W-1:0] sc,
    output logic [SUB_W-1:0] fsk_per,
    output logic             phase,
    output logic             bp_level
);

    logic prev_eff;
    logic phase_eff;
    logic phase_next;

    // Subcarrier period for the bit currently being sent.
    always_comb fsk_per = fsk_period(mod_sel, cur_bit);

    // Phase rule at a bit start; history is cleared after idle.
    always_comb begin
        prev_eff  = active ? cur_bit : 1'b0;
        phase_eff = active ? phase   : 1'b0;
        case (mod_sel)
            MODE_PSK_CH: phase_next = phase_eff ^ (data_bit ^ prev_eff);
            MODE_PSK_HI: phase_next = phase_eff ^ data_bit;
            MODE_PSK_UP: phase_next = phase_eff ^ (data_bit & ~prev_eff);
            default:     phase_next = phase_eff;
        endcase
    end

    // FSK subcarrier counter, restarted at every bit start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sc <= '0;
        else if (load)
            sc <= '0;
        else if (active)
            sc <= (sc == fsk_per - SUB_W'(1)) ? '0 : sc + SUB_W'(1);
    end

    // PSK phase flag and biphase start level, updated on bit acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= 1'b0;
            bp_level <= 1'b1;
        end else if (load) begin
            phase    <= phase_next;
            bp_level <= active ? ~(bp_level ^ cur_bit) : 1'b1;
        end
    end

    assert_fsk_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sc == '0));

    assert_psk_hi_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && active && mod_sel == MODE_PSK_HI && data_bit) |=> (phase != $past(phase)));

    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(phase));

endmodule

// File: rtl/lm_coder.sv
// Output coder: forms the damping level for the current clock from the
// bit, the position in the bit and the carrier state, then applies
// inversion. Purely combinational; idle and reserved settings give 0.
module lm_coder
    import lm_enc_pkg::*;
#(
    parameter int PER_W     = 8,
    parameter int PSK_STEPS = 3
) (
    input  logic             active,
    input  logic             cur_bit,
    input  logic [PER_W-1:0] cnt,
    input  logic [PER_W-1:0] period,
    input  logic [SUB_W-1:0] sc,
    input  logic [SUB_W-1:0] fsk_per,
    input  logic             phase,
    input  logic             bp_level,
    input  logic [4:0]       mod_sel,
    input  logic [1:0]       psk_sel,
    input  logic             invert,
    output logic             damp
);

    scheme_e          sch;
    logic [PER_W-1:0] half;
    logic [PSK_STEPS-1:0] psk_base;
    logic             psk_ok;
    logic             carrier;
    logic             raw;

    // One carrier candidate per PSK subcarrier period (2, 4, 8, ...).
    for (genvar g = 0; g < PSK_STEPS; g++) begin : g_psk
        assign psk_base[g] = ~cnt[g];
    end

    // Choose the PSK carrier and flag the reserved selection.
    always_comb begin
        psk_ok  = (32'(psk_sel) < PSK_STEPS);
        carrier = psk_ok ? psk_base[psk_sel] : 1'b0;
    end

    // Coding of the current bit for the selected scheme.
    always_comb begin
        sch  = scheme_of(mod_sel);
        half = period >> 1;
        case (sch)
            SCH_NRZ: raw = cur_bit;
            SCH_MAN: raw = (cnt < half) ? ~cur_bit : cur_bit;
            SCH_BIP: raw = (cur_bit && cnt >= half) ? ~bp_level : bp_level;
            SCH_FSK: raw = (sc < ((fsk_per + SUB_W'(1)) >> 1));
            SCH_PSK: raw = carrier ^ phase;
            default: raw = 1'b0;
        endcase
    end

    // Final gate: only a running bit in a valid setting moves the switch.
    always_comb begin
        if (active && sch != SCH_OFF && !(sch == SCH_PSK && !psk_ok))
            damp = raw ^ invert;
        else
            damp = 1'b0;
    end

endmodule

// File: rtl/lm_encoder.sv
// Top of the load modulation encoder: bit timer, carrier state and output
// coder. One clock is one field clock. Assumes configuration inputs change
// only while idle.
module lm_encoder
    import lm_enc_pkg::*;
#(
    parameter int RATE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_compat,
    input  logic [RATE_W-1:0] rate_code,
    input  logic [4:0]        mod_sel,
    input  logic [1:0]        psk_sel,
    input  logic              invert,
    input  logic              data_bit,
    input  logic              data_valid,
    output logic              damp,
    output logic              bit_done
);

    localparam int PER_W     = RATE_W + 2;
    localparam int PSK_STEPS = 3;

    logic             active;
    logic             cur_bit;
    logic             load;
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] period;
    logic [SUB_W-1:0] sc;
    logic [SUB_W-1:0] fsk_per;
    logic             phase;
    logic             bp_level;

    lm_bit_timer #(.RATE_W(RATE_W), .PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rate_compat(rate_compat), .rate_code(rate_code),
        .data_bit(data_bit), .data_valid(data_valid), .active(active),
        .cur_bit(cur_bit), .cnt(cnt), .period(period), .load(load), .bit_done(bit_done)
    );

    lm_carrier u_carrier (
        .clk(clk), .rst_n(rst_n), .active(active), .load(load), .data_bit(data_bit),
        .cur_bit(cur_bit), .mod_sel(mod_sel), .sc(sc), .fsk_per(fsk_per),
        .phase(phase), .bp_level(bp_level)
    );

    lm_coder #(.PER_W(PER_W), .PSK_STEPS(PSK_STEPS)) u_coder (
        .active(active), .cur_bit(cur_bit), .cnt(cnt), .period(period), .sc(sc),
        .fsk_per(fsk_per), .phase(phase), .bp_level(bp_level), .mod_sel(mod_sel),
        .psk_sel(psk_sel), .invert(invert), .damp(damp)
    );

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !damp);

    assert_manch_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && mod_sel == MODE_MAN && $stable(mod_sel)
         && $stable(invert) && cnt == (period >> 1)) |-> (damp != $past(damp)));

    assert_biphase_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(bit_done) && cnt == '0 && mod_sel == MODE_BIP
         && $stable(mod_sel) && $stable(invert)) |-> (damp != $past(damp)));

endmodule

// File: tb/lm_encoder_bench.sv
// Directed bench for lm_encoder: one task per scenario, each streaming bits
// and comparing every clock against a model built from the requirements.
module lm_encoder_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_compat = 1'b0;
    logic [5:0] rate_code = '0;
    logic [4:0] mod_sel = '0;
    logic [1:0] psk_sel = '0;
    logic       invert = 1'b0;
    logic       data_bit = 1'b0;
    logic       data_valid = 1'b0;
    logic       damp;
    logic       bit_done;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lm_encoder u_lm_encoder (
        .clk(clk), .rst_n(rst_n), .rate_compat(rate_compat), .rate_code(rate_code),
        .mod_sel(mod_sel), .psk_sel(psk_sel), .invert(invert), .data_bit(data_bit),
        .data_valid(data_valid), .damp(damp), .bit_done(bit_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bit_len(input logic compat, input logic [5:0] code);
        int tbl[8] = '{8, 16, 32, 40, 50, 64, 100, 128};
        return compat ? tbl[code[2:0]] : 2 * int'(code) + 2;
    endfunction

    // Expected damping level from the coding rules of R3..R10.
    function automatic logic model(input logic [4:0] m, input logic [1:0] ps, input logic b,
                                   input int c, input int p, input logic ph,
                                   input logic lvl, input logic inv);
        logic r;
        int s;
        int q;
        case (m)
            5'b00000: r = b;
            5'b01000: r = (c < p/2) ? ~b : b;
            5'b10000: r = (b && c >= p/2) ? ~lvl : lvl;
            5'b00100, 5'b00101, 5'b00110, 5'b00111: begin
                if (m == 5'b00100)      s = b ? 8 : 5;
                else if (m == 5'b00101) s = b ? 8 : 10;
                else if (m == 5'b00110) s = b ? 5 : 8;
                else                    s = b ? 10 : 8;
                r = ((c % s) < (s + 1) / 2);
            end
            5'b00001, 5'b00010, 5'b00011: begin
                if (ps == 2'b11) return 1'b0;
                q = 2 << ps;
                r = ((c % q) < q / 2) ^ ph;
            end
            default: return 1'b0;
        endcase
        return r ^ inv;
    endfunction

    // Stream n bits (LSB first) back to back and check every clock.
    task automatic run_stream(input string req, input logic compat, input logic [5:0] code,
                              input logic [4:0] m, input logic [1:0] ps, input logic inv,
                              input logic [31:0] bits, input int n);
        int p = bit_len(compat, code);
        logic ph = 1'b0;
        logic pb = 1'b0;
        logic lvl = 1'b1;
        logic endl;
        @(negedge clk);
        rate_compat = compat; rate_code = code; mod_sel = m; psk_sel = ps; invert = inv;
        data_bit = bits[0]; data_valid = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic b = bits[i];
            if (m == 5'b00001) ph = ph ^ (b ^ pb);
            if (m == 5'b00010) ph = ph ^ b;
            if (m == 5'b00011) ph = ph ^ (b & ~pb);
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                check(req, $sformatf("damp bit %0d cyc %0d", i, c), int'(damp),
                      int'(model(m, ps, b, c, p, ph, lvl, inv)));
                check("R11", $sformatf("bit_done bit %0d cyc %0d", i, c), int'(bit_done),
                      (c == p - 1) ? 1 : 0);
                if (c == p - 1) begin
                    if (i < n - 1) data_bit = bits[i+1];
                    else data_valid = 1'b0;
                end
            end
            endl = (b && p >= 2) ? ~lvl : lvl;
            lvl = ~endl;
            pb = b;
        end
        @(negedge clk);
        check("R10", "idle damp", int'(damp), 0);
        check("R11", "idle bit_done", int'(bit_done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", "reset damp", int'(damp), 0);
        check("R10", "reset bit_done", int'(bit_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "post-reset damp", int'(damp), 0);
    endtask

    task automatic t_direct();
        run_stream("R3", 1'b0, 6'd3, 5'b00000, 2'b00, 1'b0, 32'b1001101, 7);
    endtask

    task automatic t_linear_rates();
        run_stream("R1", 1'b0, 6'd0,  5'b00000, 2'b00, 1'b0, 32'b1101, 4);
        run_stream("R1", 1'b0, 6'd1,  5'b00000, 2'b00, 1'b0, 32'b10, 2);
        run_stream("R1", 1'b0, 6'd20, 5'b00000, 2'b00, 1'b0, 32'b01, 2);
        run_stream("R1", 1'b0, 6'd63, 5'b00000, 2'b00, 1'b0, 32'b10, 2);
    endtask

    task automatic t_table_rates();
        for (int k = 0; k < 8; k++)
            run_stream("R2", 1'b1, 6'(k), 5'b00000, 2'b00, 1'b0, 32'b01, 2);
    endtask

    task automatic t_manchester();
        run_stream("R4", 1'b0, 6'd7, 5'b01000, 2'b00, 1'b0, 32'b0110, 4);
        run_stream("R4", 1'b0, 6'd0, 5'b01000, 2'b00, 1'b0, 32'b00110, 5);
    endtask

    task automatic t_biphase();
        run_stream("R5", 1'b0, 6'd7, 5'b10000, 2'b00, 1'b0, 32'b001011, 6);
        run_stream("R5", 1'b0, 6'd0, 5'b10000, 2'b00, 1'b0, 32'b0111, 4);
    endtask

    task automatic t_fsk();
        for (int k = 4; k < 8; k++)
            run_stream("R6", 1'b1, 6'd5, 5'(k), 2'b00, 1'b0, 32'b0110, 4);
        run_stream("R6", 1'b0, 6'd10, 5'b00101, 2'b00, 1'b0, 32'b101, 3);
    endtask

    task automatic t_psk_carrier();
        for (int k = 0; k < 3; k++)
            run_stream("R7", 1'b1, 6'd2, 5'b00001, 2'(k), 1'b0, 32'b0110, 4);
    endtask

    task automatic t_psk_rules();
        run_stream("R8", 1'b1, 6'd2, 5'b00001, 2'b01, 1'b0, 32'b101110, 6);
        run_stream("R8", 1'b1, 6'd2, 5'b00010, 2'b00, 1'b0, 32'b101110, 6);
        run_stream("R8", 1'b1, 6'd2, 5'b00011, 2'b10, 1'b0, 32'b101101, 6);
    endtask

    task automatic t_invert();
        run_stream("R9", 1'b0, 6'd3, 5'b00000, 2'b00, 1'b1, 32'b0110, 4);
        run_stream("R9", 1'b0, 6'd5, 5'b01000, 2'b00, 1'b1, 32'b10, 2);
        run_stream("R9", 1'b1, 6'd2, 5'b00010, 2'b01, 1'b1, 32'b011, 3);
    endtask

    task automatic t_reserved();
        run_stream("R10", 1'b0, 6'd3, 5'b01001, 2'b00, 1'b1, 32'b101, 3);
        run_stream("R10", 1'b0, 6'd3, 5'b11111, 2'b00, 1'b0, 32'b11, 2);
        run_stream("R10", 1'b1, 6'd2, 5'b00001, 2'b11, 1'b1, 32'b0101, 4);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_linear_rates();
        t_table_rates();
        t_manchester();
        t_biphase();
        t_fsk();
        t_psk_carrier();
        t_psk_rules();
        t_invert();
        t_reserved();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule